// File: doc/BRIEF.md
# Dual-Key Ternary Rule Matcher for IPv4 Frames

This block keeps a small table of packet filter rules in flip-flops and classifies each frame against it. Every rule holds a source IPv4 address and a destination IPv4 address. Each of the two addresses has its own per-bit don't-care mask. A host loads or removes rules one at a time through a write port. Each write names the slot, the two addresses, the two masks and whether the slot is to be live.

On the frame side, the two addresses of the current frame are presented together with a start strobe. In that cycle, every live rule is compared in parallel against both addresses. The lowest-numbered rule that matches is reported. The verdict (frame open, match found, rule index) comes out one cycle later. It stays put for the whole frame, whatever the address inputs do, and it is withdrawn by the end strobe. A start strobe arriving while a verdict is held replaces that verdict, so frames can follow back to back.

Top module: `ternary_addr_filter`

## Requirements
- R1: While reset is asserted, and after it is released until the first start strobe, `res_valid`, `hit` and `hit_idx` are all zero, and every table slot is empty.
- R2: A cycle with `wr_en` high stores `wr_src`, `wr_src_mask`, `wr_dst`, `wr_dst_mask` and `wr_valid` into slot `wr_idx`. Writing with `wr_valid` = 0 empties that slot.
- R3: A mask bit of 1 marks a don't-care bit; a mask bit of 0 requires equality. A rule matches only when both the source address and the destination address agree on every bit that is not a don't-care.
- R4: An empty slot never matches, even when both of its masks are all ones.
- R5: When several rules match, `hit_idx` reports the lowest slot number.
- R6: If `sof` is high at a clock edge, the addresses on `key_src` and `key_dst` at that edge are looked up. From that edge onward, `res_valid` = 1, `hit` shows the outcome and `hit_idx` shows the winning slot.
- R7: While a verdict is held and neither `sof` nor `eof` is high, `res_valid`, `hit` and `hit_idx` stay unchanged. This holds even if the address inputs change or rules are written.
- R8: `eof` high at an edge (with `sof` low) clears `res_valid`, `hit` and `hit_idx` to zero. When `sof` and `eof` are high in the same cycle, `sof` wins and a new verdict is loaded.
- R9: A rule write in the same cycle as `sof` does not affect that lookup. It takes effect from the next lookup on.
- R10: A lookup that matches no rule gives `res_valid` = 1, `hit` = 0 and `hit_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | IDX_W (4) | Slot to write |
| wr_valid | input | 1 | 1 makes the slot live, 0 empties it |
| wr_src | input | ADDR_W (32) | Rule source address |
| wr_src_mask | input | ADDR_W (32) | Source don't-care mask, 1 = ignore bit |
| wr_dst | input | ADDR_W (32) | Rule destination address |
| wr_dst_mask | input | ADDR_W (32) | Destination don't-care mask, 1 = ignore bit |
| sof | input | 1 | Frame start; the keys are looked up at this edge |
| eof | input | 1 | Frame end; withdraws the verdict |
| key_src | input | ADDR_W (32) | Source address of the frame |
| key_dst | input | ADDR_W (32) | Destination address of the frame |
| res_valid | output | 1 | A verdict is held for the open frame |
| hit | output | 1 | The held verdict found a matching rule |
| hit_idx | output | IDX_W (4) | Slot of the winning rule, zero on a miss |

## Verification
Table slots cannot be read back, so a corrupted slot shows only at a lookup. It appears as a wrong `hit` or `hit_idx` one cycle after the first `sof` whose keys touch that slot. A frame-state fault shows within one cycle of `sof` or `eof`, or as drift of the held outputs during a frame. For this reason, the bench runs lookups after every kind of write and compares all three outputs on every cycle, including the cycles inside frames while the keys move.

// File: rtl/taf_pkg.sv
package taf_pkg;
  localparam int unsigned TAF_DEF_ENTRIES = 16;
  localparam int unsigned TAF_DEF_ADDR_W  = 32;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_HELD = 1'b1
  } frame_st_e;
endpackage

// File: rtl/taf_rst_sync.sv
module taf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/taf_rule_store.sv
module taf_rule_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            wr_valid,
  input  logic [ADDR_W-1:0]               wr_src,
  input  logic [ADDR_W-1:0]               wr_src_mask,
  input  logic [ADDR_W-1:0]               wr_dst,
  input  logic [ADDR_W-1:0]               wr_dst_mask,
  output logic [ENTRIES-1:0]              rule_live,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  rule_src,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  rule_src_dc,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  rule_dst,
  output logic [ENTRIES-1:0][ADDR_W-1:0]  rule_dst_dc
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic              sel;
    logic              live_d;
    logic              live_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] src_dc_q;
    logic [ADDR_W-1:0] dst_q;
    logic [ADDR_W-1:0] dst_dc_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      live_d = live_q;
      if (sel) begin
        live_d = wr_valid;
      end
    end

    // Only the live bit is reset; data is qualified by it.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= 1'b0;
      end else begin
        live_q <= live_d;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        src_q    <= wr_src;
        src_dc_q <= wr_src_mask;
        dst_q    <= wr_dst;
        dst_dc_q <= wr_dst_mask;
      end
    end

    assign rule_live[g]   = live_q;
    assign rule_src[g]    = src_q;
    assign rule_src_dc[g] = src_dc_q;
    assign rule_dst[g]    = dst_q;
    assign rule_dst_dc[g] = dst_dc_q;
  end
endmodule

// File: rtl/taf_match_array.sv
module taf_match_array #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0]               key_src,
  input  logic [ADDR_W-1:0]               key_dst,
  input  logic [ENTRIES-1:0]              rule_live,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_src,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_src_dc,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_dst,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_dst_dc,
  output logic [ENTRIES-1:0]              match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] src_miss;
    logic [ADDR_W-1:0] dst_miss;

    // A differing bit counts only where the don't-care mask is clear.
    assign src_miss = (key_src ^ rule_src[g]) & ~rule_src_dc[g];
    assign dst_miss = (key_dst ^ rule_dst[g]) & ~rule_dst_dc[g];
    assign match_vec[g] = rule_live[g] && !(|src_miss) && !(|dst_miss);
  end
endmodule

// File: rtl/taf_prio_pick.sv
module taf_prio_pick #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    // Scan downward so the lowest set bit is the last one written.
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ternary_addr_filter.sv
module ternary_addr_filter
  import taf_pkg::*;
#(
  parameter int unsigned ENTRIES = TAF_DEF_ENTRIES,
  parameter int unsigned ADDR_W  = TAF_DEF_ADDR_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_src_mask,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic [ADDR_W-1:0] wr_dst_mask,
  input  logic              sof,
  input  logic              eof,
  input  logic [ADDR_W-1:0] key_src,
  input  logic [ADDR_W-1:0] key_dst,
  output logic              res_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic                            rst_s_n;
  logic [ENTRIES-1:0]              rule_live;
  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_src;
  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_src_dc;
  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_dst;
  logic [ENTRIES-1:0][ADDR_W-1:0]  rule_dst_dc;
  logic [ENTRIES-1:0]              match_vec;
  logic                            any_match;
  logic [IDX_W-1:0]                win_idx;

  frame_st_e        st_q, st_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             res_en;

  taf_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  taf_rule_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_valid    (wr_valid),
    .wr_src      (wr_src),
    .wr_src_mask (wr_src_mask),
    .wr_dst      (wr_dst),
    .wr_dst_mask (wr_dst_mask),
    .rule_live   (rule_live),
    .rule_src    (rule_src),
    .rule_src_dc (rule_src_dc),
    .rule_dst    (rule_dst),
    .rule_dst_dc (rule_dst_dc)
  );

  taf_match_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cmp (
    .key_src     (key_src),
    .key_dst     (key_dst),
    .rule_live   (rule_live),
    .rule_src    (rule_src),
    .rule_src_dc (rule_src_dc),
    .rule_dst    (rule_dst),
    .rule_dst_dc (rule_dst_dc),
    .match_vec   (match_vec)
  );

  taf_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
    .req (match_vec),
    .any (any_match),
    .idx (win_idx)
  );

  // Result registers move only on a frame strobe.
  assign res_en = sof | eof;

  always_comb begin
    st_d  = st_q;
    hit_d = hit_q;
    idx_d = idx_q;
    if (sof) begin
      st_d  = FR_HELD;
      hit_d = any_match;
      idx_d = any_match ? win_idx : '0;
    end else if (eof) begin
      st_d  = FR_IDLE;
      hit_d = 1'b0;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= FR_IDLE;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else if (res_en) begin
      st_q  <= st_d;
      hit_q <= hit_d;
      idx_q <= idx_d;
    end
  end

  assign res_valid = (st_q == FR_HELD);
  assign hit       = hit_q;
  assign hit_idx   = idx_q;
endmodule

// File: rtl/ternary_addr_filter_chk.sv
module ternary_addr_filter_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             sof,
  input logic             eof,
  input logic             res_valid,
  input logic             hit,
  input logic [IDX_W-1:0] hit_idx
);
  // R1: outputs quiet while reset holds
  always @(negedge clk) begin
    if (!rst_s_n) begin
      a_r1_reset_quiet: assert (!res_valid && !hit && hit_idx == '0)
        else $error("a_r1_reset_quiet");
    end
  end

  // R6: a start strobe opens a verdict
  a_r6_sof_opens: assert property (@(posedge clk) disable iff (!rst_s_n)
    sof |=> res_valid);

  // R6: a hit exists only inside an open verdict
  a_r6_hit_in_frame: assert property (@(posedge clk) disable iff (!rst_s_n)
    hit |-> res_valid);

  // R7: verdict frozen between strobes
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sof && !eof) |=> ($stable(res_valid) && $stable(hit) && $stable(hit_idx)));

  // R8: end strobe alone withdraws everything
  a_r8_eof_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eof && !sof) |=> (!res_valid && !hit && hit_idx == '0));

  // R10: index is zero whenever nothing matched
  a_r10_miss_idx: assert property (@(posedge clk) disable iff (!rst_s_n)
    !hit |-> (hit_idx == '0));
endmodule

bind ternary_addr_filter ternary_addr_filter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .sof       (sof),
  .eof       (eof),
  .res_valid (res_valid),
  .hit       (hit),
  .hit_idx   (hit_idx)
);

// File: tb/sim_ternary_addr_filter.sv
`timescale 1ns/1ps
module sim_ternary_addr_filter;
  localparam int N  = 16;
  localparam int AW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_valid, sof, eof;
  logic [IW-1:0] wr_idx;
  logic [AW-1:0] wr_src, wr_src_mask, wr_dst, wr_dst_mask, key_src, key_dst;
  logic          res_valid, hit;
  logic [IW-1:0] hit_idx;

  int    n_run  = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // behavioural reference
  bit            m_live [N];
  bit [AW-1:0]   m_src  [N];
  bit [AW-1:0]   m_sdc  [N];
  bit [AW-1:0]   m_dst  [N];
  bit [AW-1:0]   m_ddc  [N];
  bit            m_rv, m_hit;
  int            m_idx;

  always #2.5 clk = ~clk;

  ternary_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_src(wr_src), .wr_src_mask(wr_src_mask), .wr_dst(wr_dst),
    .wr_dst_mask(wr_dst_mask), .sof(sof), .eof(eof), .key_src(key_src),
    .key_dst(key_dst), .res_valid(res_valid), .hit(hit), .hit_idx(hit_idx)
  );

  function automatic bit rule_ok(int i, bit [AW-1:0] s, bit [AW-1:0] d);
    if (!m_live[i]) return 0;
    for (int b = 0; b < AW; b++) begin
      if (!m_sdc[i][b] && s[b] != m_src[i][b]) return 0;
      if (!m_ddc[i][b] && d[b] != m_dst[i][b]) return 0;
    end
    return 1;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_live[i] = 0;
      m_rv = 0; m_hit = 0; m_idx = 0;
      return;
    end
    if (sof) begin
      int w = -1;
      for (int i = 0; i < N; i++) if (w < 0 && rule_ok(i, key_src, key_dst)) w = i;
      m_rv = 1; m_hit = (w >= 0); m_idx = (w >= 0) ? w : 0;
    end else if (eof) begin
      m_rv = 0; m_hit = 0; m_idx = 0;
    end
    if (wr_en) begin
      m_live[wr_idx] = wr_valid;
      m_src[wr_idx] = wr_src; m_sdc[wr_idx] = wr_src_mask;
      m_dst[wr_idx] = wr_dst; m_ddc[wr_idx] = wr_dst_mask;
    end
  endtask

  task automatic compare();
    n_run++;
    if (res_valid !== m_rv || hit !== m_hit || int'(hit_idx) != m_idx || $isunknown(hit_idx)) begin
      n_fail++;
      $display("FAIL %s t=%0t: got rv=%b hit=%b idx=%0d, expected rv=%b hit=%b idx=%0d",
               cur_req, $time, res_valid, hit, hit_idx, m_rv, m_hit, m_idx);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #0.5;
    model_edge();
    @(negedge clk);
    compare();
    wr_en = 0; sof = 0; eof = 0;
  endtask

  task automatic wr(int i, bit v, bit [AW-1:0] s, bit [AW-1:0] sm, bit [AW-1:0] d, bit [AW-1:0] dm);
    wr_en = 1; wr_idx = IW'(i); wr_valid = v;
    wr_src = s; wr_src_mask = sm; wr_dst = d; wr_dst_mask = dm;
    cyc();
  endtask

  task automatic look(bit [AW-1:0] s, bit [AW-1:0] d, bit expect_hit, int expect_idx);
    key_src = s; key_dst = d; sof = 1;
    cyc();
    if (hit !== expect_hit || (expect_hit && int'(hit_idx) != expect_idx)) begin
      n_fail++;
      $display("FAIL %s directed: got hit=%b idx=%0d, expected hit=%b idx=%0d",
               cur_req, hit, hit_idx, expect_hit, expect_idx);
    end
    n_run++;
    key_src = ~s; key_dst = ~d;   // R7: keys move during the frame
    cyc(); cyc();
    eof = 1;
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (%s)", cur_req);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_valid = 0; wr_idx = 0; sof = 0; eof = 0;
    wr_src = 0; wr_src_mask = 0; wr_dst = 0; wr_dst_mask = 0; key_src = 0; key_dst = 0;
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();
    look(32'h0A000001, 32'hC0A80101, 0, 0);          // R1 empty table, R10 miss

    cur_req = "R2";
    wr(3, 1, 32'h0A000001, 32'h0, 32'hC0A80101, 32'h0);
    look(32'h0A000001, 32'hC0A80101, 1, 3);
    wr(3, 0, 32'h0A000001, 32'h0, 32'hC0A80101, 32'h0);
    look(32'h0A000001, 32'hC0A80101, 0, 0);

    cur_req = "R3";
    wr(5, 1, 32'h0A000000, 32'h000000FF, 32'hC0A80107, 32'h0);
    look(32'h0A000037, 32'hC0A80107, 1, 5);
    look(32'h0A000137, 32'hC0A80107, 0, 0);
    look(32'h0A000037, 32'hC0A80108, 0, 0);

    cur_req = "R4";
    wr(2, 0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
    look(32'h12345678, 32'h9ABCDEF0, 0, 0);

    cur_req = "R5";
    wr(9, 1, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
    wr(12, 1, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);
    look(32'h0A0000AA, 32'hC0A80107, 1, 5);
    look(32'h12345678, 32'h9ABCDEF0, 1, 9);
    wr(9, 0, 32'h0, 32'h0, 32'h0, 32'h0);
    look(32'h12345678, 32'h9ABCDEF0, 1, 12);

    cur_req = "R6";
    key_src = 32'h0A000001; key_dst = 32'hC0A80107; sof = 1; cyc();
    cur_req = "R7";
    wr(0, 1, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF);   // write during held verdict
    key_src = 32'h77777777; cyc(); cyc();
    cur_req = "R8";
    key_src = 32'h55555555; sof = 1; eof = 1; cyc();     // sof wins -> slot 0
    eof = 1; cyc(); cyc();
    wr(0, 0, 32'h0, 32'h0, 32'h0, 32'h0);

    cur_req = "R9";
    key_src = 32'h0A000001; key_dst = 32'hC0A80107; sof = 1;
    wr_en = 1; wr_idx = 1; wr_valid = 1; wr_src = 32'h0A000001; wr_src_mask = 0;
    wr_dst = 32'hC0A80107; wr_dst_mask = 0;
    cyc();                                               // old table -> slot 5
    eof = 1; cyc();
    look(32'h0A000001, 32'hC0A80107, 1, 1);

    cur_req = "R10";
    wr(12, 0, 32'h0, 32'h0, 32'h0, 32'h0);
    look(32'hDEADBEEF, 32'h01020304, 0, 0);

    cur_req = "R3";
    for (int k = 0; k < 600; k++) begin
      bit [AW-1:0] pool [4];
      pool[0] = 32'h0A000001; pool[1] = 32'h0A0000FF; pool[2] = 32'hC0A80107; pool[3] = 32'h0B000001;
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_idx = IW'($urandom_range(0, N - 1)); wr_valid = ($urandom_range(0, 4) != 0);
        wr_src = pool[$urandom_range(0, 3)]; wr_dst = pool[$urandom_range(0, 3)];
        wr_src_mask = ($urandom_range(0, 2) == 0) ? 32'h000000FF : 32'h0;
        wr_dst_mask = ($urandom_range(0, 3) == 0) ? 32'hFFFFFFFF : 32'h0;
      end
      key_src = pool[$urandom_range(0, 3)]; key_dst = pool[$urandom_range(0, 3)];
      sof = ($urandom_range(0, 3) == 0); eof = ($urandom_range(0, 4) == 0);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule